// File: doc/BRIEF.md
# Exception Return Control Unit

This block carries out the privileged return-from-exception instruction and its link-keeping variant. Each clock it takes a 32-bit instruction word with a valid strobe. It also takes a snapshot of the system-control state: the error-level and exception-level flags, the boot-vector flag, the shadow-set fields, the two saved return addresses and the load-linked bit. From these it works out one of four outcomes: idle, reserved-instruction exception, coprocessor-unusable exception, or a completed return.

A completed return gives a sign-extended 64-bit redirect target, the updated flag, shadow-set and link-bit values, and a one-cycle hazard-barrier pulse for the pipeline. Every output is registered, so results appear one clock after the strobe. When no return completes, the state outputs simply carry the sampled state inputs through unchanged. The surrounding pipeline writes those values back every cycle.

Top module: `xret_unit`

## Requirements
- R1: The word is recognised only when bits 31:26 are 001000, bits 15:9 are 1111001 and bits 8:0 are 101111111 (bits 25:17 are ignored). A strobe with a non-matching word, or no strobe, raises no pulse and no exception, and the state outputs equal the sampled state inputs.
- R2: A recognised word with bit 16 = 1 (variant) while `variant_ok` is 0 raises `ri_exc`, and no state output changes.
- R3: When R2 does not apply and `cop_en` is 0, a recognised word raises `cu_exc` and no state output changes; `ri_exc` wins over `cu_exc`.
- R4: On a completed return with `err_lvl_i` = 1, `next_pc` is the sign-extended `err_pc_i`, `err_lvl_o` is 0, and the exception-level and shadow-set outputs equal their inputs.
- R5: On a completed return with `err_lvl_i` = 0, `next_pc` is the sign-extended `exc_pc_i` and `exc_lvl_o` is 0.
- R6: On the R5 path only, `css_o` takes `pss_i` when `hss_i` is non-zero and `boot_vec_i` is 0; otherwise `css_o` equals `css_i`.
- R7: A completed return clears `link_o` when bit 16 is 0 and keeps `link_i` when bit 16 is 1.
- R8: `redirect` and `hazard_clr` pulse together for exactly the cycle after a strobe that completes a return, and never with an exception; `next_pc` holds its last value otherwise.
- R9: Outputs are registered one cycle after the inputs; a synchronous active-high reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction strobe |
| instr_word | input | 32 | Instruction word |
| variant_ok | input | 1 | Link-keeping variant is supported |
| cop_en | input | 1 | Privileged coprocessor usable in the current mode |
| err_lvl_i | input | 1 | Error-level flag |
| exc_lvl_i | input | 1 | Exception-level flag |
| boot_vec_i | input | 1 | Boot-vector flag |
| hss_i | input | 4 | Highest shadow set |
| pss_i | input | 4 | Previous shadow set |
| css_i | input | 4 | Current shadow set |
| err_pc_i | input | 32 | Error return address |
| exc_pc_i | input | 32 | Exception return address |
| link_i | input | 1 | Load-linked bit |
| redirect | output | 1 | Fetch redirect pulse |
| hazard_clr | output | 1 | Execution and instruction hazard barrier pulse |
| ri_exc | output | 1 | Reserved-instruction exception request |
| cu_exc | output | 1 | Coprocessor-unusable exception request |
| next_pc | output | 64 | Redirect target |
| err_lvl_o | output | 1 | Updated error-level flag |
| exc_lvl_o | output | 1 | Updated exception-level flag |
| css_o | output | 4 | Updated current shadow set |
| link_o | output | 1 | Updated load-linked bit |

## Verification
The assertions assume the state inputs are stable during the cycle they are sampled. They also assume the instruction word is meaningful only when the strobe is high, and that reset lasts at least one edge. The stimulus changes inputs only on falling edges and holds the strobe low during reset. A large share of the words it sends match the fixed fields, and the remaining strobed words have exactly one fixed bit flipped. This exercises both the ignored don't-care bits and near-miss encodings. Error level, boot vector and the highest shadow set are each driven to zero and non-zero, so both sides of the shadow-set condition occur on each return path.

// File: rtl/xret_pkg.sv
package xret_pkg;
    localparam int unsigned INSTR_W = 32;
    localparam logic [INSTR_W-1:0] XRET_MASK = 32'hFC00_FFFF;
    localparam logic [INSTR_W-1:0] XRET_PATT = 32'h2000_F37F;
    localparam int unsigned VARIANT_BIT = 16;

    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,
        OUT_RI   = 2'd1,
        OUT_CU   = 2'd2,
        OUT_RET  = 2'd3
    } xret_outcome_e;
endpackage

// File: rtl/xret_decode.sv
module xret_decode
    import xret_pkg::*;
(
    input  logic [INSTR_W-1:0] word_i,
    output logic               match_o,
    output logic               variant_o
);
    always_comb begin
        match_o   = ((word_i & XRET_MASK) == XRET_PATT);
        variant_o = word_i[VARIANT_BIT];
    end
endmodule

// File: rtl/xret_arbiter.sv
module xret_arbiter
    import xret_pkg::*;
(
    input  logic          valid_i,
    input  logic          match_i,
    input  logic          variant_i,
    input  logic          variant_ok_i,
    input  logic          cop_en_i,
    output xret_outcome_e outcome_o
);
    always_comb begin
        if (!(valid_i && match_i))
            outcome_o = OUT_IDLE;
        else if (variant_i && !variant_ok_i)
            outcome_o = OUT_RI;
        else if (!cop_en_i)
            outcome_o = OUT_CU;
        else
            outcome_o = OUT_RET;
    end
endmodule

// File: rtl/xret_sext.sv
module xret_sext #(
    parameter int unsigned IN_W  = 32,
    parameter int unsigned OUT_W = 64
) (
    input  logic [IN_W-1:0]  a_i,
    output logic [OUT_W-1:0] y_o
);
    localparam int unsigned EXT_W = OUT_W - IN_W;
    generate
        if (EXT_W == 0) begin : g_same
            assign y_o = a_i;
        end else begin : g_ext
            assign y_o = {{EXT_W{a_i[IN_W-1]}}, a_i};
        end
    endgenerate
endmodule

// File: rtl/xret_unit.sv
module xret_unit
    import xret_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned XPC_W = 64,
    parameter int unsigned SS_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  instr_valid,
    input  logic [INSTR_W-1:0]    instr_word,
    input  logic                  variant_ok,
    input  logic                  cop_en,
    input  logic                  err_lvl_i,
    input  logic                  exc_lvl_i,
    input  logic                  boot_vec_i,
    input  logic [SS_W-1:0]       hss_i,
    input  logic [SS_W-1:0]       pss_i,
    input  logic [SS_W-1:0]       css_i,
    input  logic [PC_W-1:0]       err_pc_i,
    input  logic [PC_W-1:0]       exc_pc_i,
    input  logic                  link_i,
    output logic                  redirect,
    output logic                  hazard_clr,
    output logic                  ri_exc,
    output logic                  cu_exc,
    output logic [XPC_W-1:0]      next_pc,
    output logic                  err_lvl_o,
    output logic                  exc_lvl_o,
    output logic [SS_W-1:0]       css_o,
    output logic                  link_o
);
    typedef struct packed {
        logic             redirect;
        logic             hazard;
        logic             ri;
        logic             cu;
        logic [XPC_W-1:0] pc;
        logic             err;
        logic             exc;
        logic [SS_W-1:0]  css;
        logic             link;
    } xret_out_t;

    logic          dec_match;
    logic          dec_variant;
    xret_outcome_e outcome;
    logic [XPC_W-1:0] err_pc_ext;
    logic [XPC_W-1:0] exc_pc_ext;
    xret_out_t     st_d;
    xret_out_t     st_q;

    xret_decode u_decode (
        .word_i    (instr_word),
        .match_o   (dec_match),
        .variant_o (dec_variant)
    );

    xret_arbiter u_arb (
        .valid_i      (instr_valid),
        .match_i      (dec_match),
        .variant_i    (dec_variant),
        .variant_ok_i (variant_ok),
        .cop_en_i     (cop_en),
        .outcome_o    (outcome)
    );

    xret_sext #(.IN_W(PC_W), .OUT_W(XPC_W)) u_sext_err (
        .a_i (err_pc_i),
        .y_o (err_pc_ext)
    );

    xret_sext #(.IN_W(PC_W), .OUT_W(XPC_W)) u_sext_exc (
        .a_i (exc_pc_i),
        .y_o (exc_pc_ext)
    );

    always_comb begin
        st_d          = st_q;
        st_d.redirect = 1'b0;
        st_d.hazard   = 1'b0;
        st_d.ri       = 1'b0;
        st_d.cu       = 1'b0;
        st_d.err      = err_lvl_i;
        st_d.exc      = exc_lvl_i;
        st_d.css      = css_i;
        st_d.link     = link_i;
        unique case (outcome)
            OUT_RI: st_d.ri = 1'b1;
            OUT_CU: st_d.cu = 1'b1;
            OUT_RET: begin
                st_d.redirect = 1'b1;
                st_d.hazard   = 1'b1;
                if (err_lvl_i) begin
                    st_d.pc  = err_pc_ext;
                    st_d.err = 1'b0;
                end else begin
                    st_d.pc  = exc_pc_ext;
                    st_d.exc = 1'b0;
                    if ((hss_i != '0) && !boot_vec_i)
                        st_d.css = pss_i;
                end
                if (!dec_variant)
                    st_d.link = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign redirect   = st_q.redirect;
    assign hazard_clr = st_q.hazard;
    assign ri_exc     = st_q.ri;
    assign cu_exc     = st_q.cu;
    assign next_pc    = st_q.pc;
    assign err_lvl_o  = st_q.err;
    assign exc_lvl_o  = st_q.exc;
    assign css_o      = st_q.css;
    assign link_o     = st_q.link;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !(instr_valid && dec_match) |=> (!redirect && !ri_exc && !cu_exc
            && err_lvl_o == $past(err_lvl_i) && exc_lvl_o == $past(exc_lvl_i)
            && link_o == $past(link_i)));

    assert_ri_raise_R2: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && dec_match && dec_variant && !variant_ok)
            |=> (ri_exc && !cu_exc && !redirect && css_o == $past(css_i)));

    assert_cu_raise_R3: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && dec_match && !(dec_variant && !variant_ok) && !cop_en)
            |=> (cu_exc && !ri_exc && link_o == $past(link_i)));

    assert_err_path_R4: assert property (@(posedge clk) disable iff (rst)
        (outcome == OUT_RET && err_lvl_i)
            |=> (!err_lvl_o && exc_lvl_o == $past(exc_lvl_i)
                 && next_pc[PC_W-1:0] == $past(err_pc_i)));

    assert_exc_path_R5: assert property (@(posedge clk) disable iff (rst)
        (outcome == OUT_RET && !err_lvl_i)
            |=> (!exc_lvl_o && next_pc[PC_W-1:0] == $past(exc_pc_i)));

    assert_link_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (outcome == OUT_RET && !instr_word[VARIANT_BIT]) |=> !link_o);

    assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (rst)
        (redirect == hazard_clr) && $countones({redirect, ri_exc, cu_exc}) <= 1);

    assert_pc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (outcome != OUT_RET) |=> $stable(next_pc));
endmodule

// File: tb/xret_unit_tb.sv
module xret_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [31:0] instr_word;
    logic        variant_ok, cop_en, err_lvl_i, exc_lvl_i, boot_vec_i, link_i;
    logic [3:0]  hss_i, pss_i, css_i;
    logic [31:0] err_pc_i, exc_pc_i;
    logic        redirect, hazard_clr, ri_exc, cu_exc;
    logic [63:0] next_pc;
    logic        err_lvl_o, exc_lvl_o, link_o;
    logic [3:0]  css_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic        e_red, e_ri, e_cu, e_err, e_exc, e_link;
    logic [63:0] e_pc;
    logic [3:0]  e_css;

    always #10 clk = ~clk;

    xret_unit dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .variant_ok(variant_ok), .cop_en(cop_en), .err_lvl_i(err_lvl_i),
        .exc_lvl_i(exc_lvl_i), .boot_vec_i(boot_vec_i), .hss_i(hss_i),
        .pss_i(pss_i), .css_i(css_i), .err_pc_i(err_pc_i), .exc_pc_i(exc_pc_i),
        .link_i(link_i), .redirect(redirect), .hazard_clr(hazard_clr),
        .ri_exc(ri_exc), .cu_exc(cu_exc), .next_pc(next_pc),
        .err_lvl_o(err_lvl_o), .exc_lvl_o(exc_lvl_o), .css_o(css_o), .link_o(link_o)
    );

    function automatic logic [31:0] mk_word(input logic [8:0] dc, input logic nc);
        return {6'b001000, dc, nc, 2'b11, 5'b11001, 3'b101, 3'b111, 3'b111};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: evaluates the driven inputs for the next edge
    task automatic model();
        bit hit, nc;
        hit = instr_valid && instr_word[31:26] == 6'b001000
              && instr_word[15:9] == 7'b1111001 && instr_word[8:0] == 9'b101111111;
        nc = instr_word[16];
        e_red = 0; e_ri = 0; e_cu = 0;
        e_err = err_lvl_i; e_exc = exc_lvl_i; e_css = css_i; e_link = link_i;
        if (hit) begin
            if (nc && !variant_ok) e_ri = 1;
            else if (!cop_en) e_cu = 1;
            else begin
                e_red = 1;
                if (err_lvl_i) begin
                    e_pc = {{32{err_pc_i[31]}}, err_pc_i};
                    e_err = 0;
                end else begin
                    e_pc = {{32{exc_pc_i[31]}}, exc_pc_i};
                    e_exc = 0;
                    if (hss_i > 0 && !boot_vec_i) e_css = pss_i;
                end
                if (!nc) e_link = 0;
            end
        end
    endtask

    task automatic compare_all();
        chk("R8 redirect", {63'd0, redirect}, {63'd0, e_red});
        chk("R8 hazard_clr", {63'd0, hazard_clr}, {63'd0, e_red});
        chk("R2 ri_exc", {63'd0, ri_exc}, {63'd0, e_ri});
        chk("R3 cu_exc", {63'd0, cu_exc}, {63'd0, e_cu});
        chk("R4/R5 next_pc", next_pc, e_pc);
        chk("R4 err_lvl_o", {63'd0, err_lvl_o}, {63'd0, e_err});
        chk("R5 exc_lvl_o", {63'd0, exc_lvl_o}, {63'd0, e_exc});
        chk("R6 css_o", {60'd0, css_o}, {60'd0, e_css});
        chk("R7 link_o", {63'd0, link_o}, {63'd0, e_link});
    endtask

    task automatic step();
        model();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic set_state(input logic err, input logic exc, input logic bev,
                             input logic [3:0] hss, input logic nc, input logic vok,
                             input logic cop);
        instr_valid = 1; instr_word = mk_word(9'h1A5, nc);
        err_lvl_i = err; exc_lvl_i = exc; boot_vec_i = bev; hss_i = hss;
        variant_ok = vok; cop_en = cop; link_i = 1;
        pss_i = 4'h9; css_i = 4'h2;
        err_pc_i = 32'h8000_1234; exc_pc_i = 32'h0040_0ABC;
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        if (!finished) begin
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; instr_valid = 0; instr_word = '0; variant_ok = 0; cop_en = 0;
        err_lvl_i = 0; exc_lvl_i = 0; boot_vec_i = 0; hss_i = 0; pss_i = 0;
        css_i = 0; err_pc_i = 0; exc_pc_i = 0; link_i = 0;
        @(negedge clk);
        err_lvl_i = 1; exc_lvl_i = 1; link_i = 1; css_i = 4'hF;
        @(posedge clk); @(negedge clk);
        // R9: reset clears every output
        chk("R9 reset outputs", {redirect, hazard_clr, ri_exc, cu_exc, err_lvl_o,
            exc_lvl_o, link_o, css_o} == '0 ? 64'd0 : 64'd1, 64'd0);
        chk("R9 reset next_pc", next_pc, 64'd0);
        rst = 0;
        e_pc = 64'd0;

        // R4: error path, sign-extended negative address
        set_state(1, 1, 0, 4'd3, 0, 1, 1); step();
        chk("R4 pc sign", next_pc, 64'hFFFF_FFFF_8000_1234);
        // R5/R6: exception path with shadow restore
        set_state(0, 1, 0, 4'd3, 0, 1, 1); step();
        chk("R6 restore", {60'd0, css_o}, 64'd9);
        // R6: boot vector blocks restore
        set_state(0, 1, 1, 4'd3, 0, 1, 1); step();
        chk("R6 bev block", {60'd0, css_o}, 64'd2);
        // R6: zero highest set blocks restore
        set_state(0, 1, 0, 4'd0, 0, 1, 1); step();
        chk("R6 hss zero", {60'd0, css_o}, 64'd2);
        // R7: variant keeps link bit
        set_state(0, 1, 0, 4'd3, 1, 1, 1); step();
        chk("R7 keep link", {63'd0, link_o}, 64'd1);
        // R2: variant without support, also with coprocessor off (priority)
        set_state(0, 1, 0, 4'd3, 1, 0, 0); step();
        chk("R2 ri priority", {62'd0, ri_exc, cu_exc}, 64'd2);
        // R3: coprocessor unusable
        set_state(1, 1, 0, 4'd3, 0, 1, 0); step();
        chk("R3 cu raise", {62'd0, cu_exc, err_lvl_o}, 64'd3);
        // R1: one fixed bit wrong
        set_state(0, 1, 0, 4'd3, 0, 1, 1); instr_word[12] = ~instr_word[12]; step();
        chk("R1 near miss", {63'd0, redirect}, 64'd0);
        // R1: no strobe
        set_state(0, 1, 0, 4'd3, 0, 1, 1); instr_valid = 0; step();
        chk("R1 no strobe", {63'd0, exc_lvl_o}, 64'd1);

        for (int i = 0; i < 3000; i++) begin
            int p;
            instr_valid = ($urandom_range(0, 9) != 0);
            instr_word = mk_word(9'($urandom), 1'($urandom));
            if ($urandom_range(0, 3) == 0) begin
                p = $urandom_range(0, 21);
                if (p < 6) instr_word[26 + p] = ~instr_word[26 + p];
                else       instr_word[p - 6] = ~instr_word[p - 6];
            end
            variant_ok = ($urandom_range(0, 3) != 0);
            cop_en = ($urandom_range(0, 4) != 0);
            err_lvl_i = 1'($urandom); exc_lvl_i = 1'($urandom);
            boot_vec_i = 1'($urandom); link_i = 1'($urandom);
            hss_i = ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom);
            pss_i = 4'($urandom); css_i = 4'($urandom);
            err_pc_i = $urandom; exc_pc_i = $urandom;
            step();
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule